// File: doc/BRIEF.md
# Four-Mode Self-Test Register with Inverted Feedback

This block is an N-bit register that sits between two pieces of logic and can serve as the test hardware for them. Two mode inputs choose what happens on each clock edge. The register can capture a parallel word. It can shift as one link of a scan chain. It can fold a parallel response word into a running signature. It can also clear itself. If the signature mode runs with its parallel inputs held at zero, the register steps through a pseudorandom sequence that can drive a block under test.

The feedback for signature mode is the inverted parity (XNOR) of a chosen set of stages. Because of this, the all-zeros word is a normal member of the maximal-length cycle. The word that locks up is all ones. A plain clear or reset therefore gives a valid start state for both pattern generation and compaction, and no external seed has to be loaded.

The test controller and the logic under test are outside this block.

Top module: `bilbo_reg`

## Requirements
- R1: When `rst` is high at a rising clock edge, `q` becomes all zeros after that edge. This takes priority over every mode.
- R2: With mode bits {`b1`,`b2`} = 2'b11 (load), `q` takes the value of `d` at the edge.
- R3: With {`b1`,`b2`} = 2'b00 (scan), `q` becomes {`q[N-2:0]`, `si`}. Stage 0 takes `si`, and stage i takes stage i-1.
- R4: With {`b1`,`b2`} = 2'b01 (clear), `q` becomes all zeros at the edge, whatever the values of `d` and `si`.
- R5: With {`b1`,`b2`} = 2'b10 (signature), stage i>0 becomes `q[i-1]` XOR `d[i]`. Stage 0 becomes the feedback bit XOR `d[0]`. The feedback bit is the XNOR of the stages selected by `TAP_MASK`. The default mask 8'hB8 selects stages 7, 5, 4 and 3.
- R6: In signature mode with `d` held at zero and a start from all zeros, the register visits 2^N-1 distinct states. It never holds all ones, and it is back at zero after exactly 2^N-1 edges.
- R7: In signature mode with `d` held at zero, the all-ones state maps to itself (this is the lock-up state).
- R8: `so` always equals the last stage, `q[N-1]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear |
| b1 | input | 1 | Mode select, upper bit |
| b2 | input | 1 | Mode select, lower bit |
| d | input | WIDTH | Parallel data / response word |
| si | input | 1 | Serial scan input |
| q | output | WIDTH | Register contents |
| so | output | 1 | Serial scan output (last stage) |

## Verification
The assertions assume that the mode bits, `d` and `si` are known and stable at every sampled rising edge. They also assume that `rst` is asserted from time zero, so that the first reference to a past value falls inside reset. The bench changes every input only at falling edges, and it holds `rst` high from the start for two edges. The lock-up check loads all ones through the load mode before it enters signature mode. The period walk runs from the cleared state with `d` tied to zero.

// File: rtl/bilbo_pkg.sv
package bilbo_pkg;

    // Mode encoding is {b1, b2}
    typedef enum logic [1:0] {
        MODE_SCAN  = 2'b00,
        MODE_CLEAR = 2'b01,
        MODE_SIG   = 2'b10,
        MODE_LOAD  = 2'b11
    } mode_e;

    // Per-stage inputs to one cell of the register
    typedef struct packed {
        logic link_in;   // value arriving from the neighbour (or chain head)
        logic data_in;   // parallel input bit
    } stage_in_t;

    function automatic mode_e decode_mode(input logic sel_hi, input logic sel_lo);
        return mode_e'({sel_hi, sel_lo});
    endfunction

    // Head of the chain: scan input in scan mode, feedback otherwise
    function automatic logic pick_head(input mode_e m, input logic scan_bit,
                                       input logic fb_bit);
        return (m == MODE_SCAN) ? scan_bit : fb_bit;
    endfunction

endpackage

// File: rtl/bilbo_feedback.sv
module bilbo_feedback #(
    parameter int              WIDTH    = 8,
    parameter logic [WIDTH-1:0] TAP_MASK = 'hB8
) (
    input  logic [WIDTH-1:0] state,
    output logic             fb
);
    // Running parity across the selected stages, built stage by stage
    logic [WIDTH:0] par_chain;

    assign par_chain[0] = 1'b0;

    for (genvar g = 0; g < WIDTH; g++) begin : g_par
        if (TAP_MASK[g]) begin : g_tap
            assign par_chain[g+1] = par_chain[g] ^ state[g];
        end else begin : g_skip
            assign par_chain[g+1] = par_chain[g];
        end
    end

    // Inverted parity: all-zeros is a live state, all-ones locks up
    assign fb = ~par_chain[WIDTH];
endmodule

// File: rtl/bilbo_stage.sv
module bilbo_stage
    import bilbo_pkg::*;
(
    input  mode_e     mode,
    input  stage_in_t cin,
    output logic      nxt
);
    always_comb begin
        unique case (mode)
            MODE_LOAD:  nxt = cin.data_in;
            MODE_SCAN:  nxt = cin.link_in;
            MODE_SIG:   nxt = cin.link_in ^ cin.data_in;
            MODE_CLEAR: nxt = 1'b0;
            default:    nxt = 1'b0;
        endcase
    end
endmodule

// File: rtl/bilbo_reg.sv
module bilbo_reg
    import bilbo_pkg::*;
#(
    parameter int               WIDTH    = 8,
    parameter logic [WIDTH-1:0] TAP_MASK = 'hB8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             b1,
    input  logic             b2,
    input  logic [WIDTH-1:0] d,
    input  logic             si,
    output logic [WIDTH-1:0] q,
    output logic             so
);
    localparam int LAST = WIDTH - 1;

    mode_e            mode;
    logic             fb;
    logic             head;
    logic [WIDTH-1:0] state_q;
    logic [WIDTH-1:0] state_d;
    stage_in_t        cin [WIDTH];

    assign mode = decode_mode(b1, b2);

    bilbo_feedback #(
        .WIDTH   (WIDTH),
        .TAP_MASK(TAP_MASK)
    ) fb_i (
        .state(state_q),
        .fb   (fb)
    );

    assign head = pick_head(mode, si, fb);

    for (genvar s = 0; s < WIDTH; s++) begin : g_stage
        if (s == 0) begin : g_first
            assign cin[s].link_in = head;
        end else begin : g_rest
            assign cin[s].link_in = state_q[s-1];
        end
        assign cin[s].data_in = d[s];

        bilbo_stage stage_i (
            .mode(mode),
            .cin (cin[s]),
            .nxt (state_d[s])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign q  = state_q;
    assign so = state_q[LAST];
endmodule

// File: rtl/bilbo_reg_chk.sv
module bilbo_reg_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             b1,
    input logic             b2,
    input logic [WIDTH-1:0] d,
    input logic             si,
    input logic [WIDTH-1:0] q,
    input logic             so
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (q == '0));

    // R2
    load_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (b1 && b2) |=> (q == $past(d)));

    // R3
    scan_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (!b1 && !b2) |=> (q == {$past(q[WIDTH-2:0]), $past(si)}));

    // R4
    clear_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (!b1 && b2) |=> (q == '0));

    // R5
    sig_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (b1 && !b2) |=> (q[WIDTH-1:1] == ($past(q[WIDTH-2:0]) ^ $past(d[WIDTH-1:1]))));

    // R7
    lockup_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (b1 && !b2 && d == '0 && q == '1) |=> (q == '1));

    // R8
    serial_out_chk: assert property (@(posedge clk) disable iff (rst)
        so == q[WIDTH-1]);
endmodule

bind bilbo_reg bilbo_reg_chk #(.WIDTH(WIDTH)) chk_i (
    .clk(clk),
    .rst(rst),
    .b1 (b1),
    .b2 (b2),
    .d  (d),
    .si (si),
    .q  (q),
    .so (so)
);

// File: tb/bilbo_reg_tb_top.sv
module bilbo_reg_tb_top;
    localparam int         W    = 8;
    localparam logic [7:0] TAPS = 8'hB8;   // stages 7,5,4,3 (R5)

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         b1  = 1'b0;
    logic         b2  = 1'b1;
    logic [W-1:0] d   = '0;
    logic         si  = 1'b0;
    logic [W-1:0] q;
    logic         so;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct {
        logic [W-1:0] exp_q;
        string        req;
    } item_t;

    item_t        sb_q[$];
    logic [W-1:0] model_q = '0;

    always #2 clk = ~clk;

    bilbo_reg #(.WIDTH(W), .TAP_MASK(TAPS)) dut_i (
        .clk(clk), .rst(rst), .b1(b1), .b2(b2),
        .d(d), .si(si), .q(q), .so(so)
    );

    task automatic check(input bit ok, input string req,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] ref_next(input logic [W-1:0] s, input logic r,
                                              input logic m1, input logic m0,
                                              input logic [W-1:0] din, input logic sin);
        logic fbv;
        if (r) return '0;
        fbv = ~(^(s & TAPS));
        case ({m1, m0})
            2'b11:   return din;
            2'b00:   return {s[W-2:0], sin};
            2'b01:   return '0;
            default: return {s[W-2:0], fbv} ^ din;
        endcase
    endfunction

    // Driver: apply one edge worth of inputs and push the expectation
    task automatic drive(input logic r, input logic m1, input logic m0,
                         input logic [W-1:0] din, input logic sin, input string req);
        item_t it;
        @(negedge clk);
        rst = r; b1 = m1; b2 = m0; d = din; si = sin;
        model_q  = ref_next(model_q, r, m1, m0, din, sin);
        it.exp_q = model_q;
        it.req   = req;
        sb_q.push_back(it);
    endtask

    // Monitor: compare after every edge that has a pending expectation
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                check(q == it.exp_q, it.req, q, it.exp_q);
                check(so == it.exp_q[W-1], "R8", {7'd0, so}, {7'd0, it.exp_q[W-1]});
            end
        end
    end

    initial begin
        #800000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit seen [256];
        bit dup;
        bit hit_ones;
        // R1 reset state
        drive(1, 0, 1, 8'h00, 0, "R1");
        drive(1, 1, 1, 8'hFF, 1, "R1");
        // R2 parallel load
        drive(0, 1, 1, 8'hA5, 0, "R2");
        drive(0, 1, 1, 8'h3C, 1, "R2");
        // R3 scan shifting, several bit patterns
        drive(0, 0, 0, 8'hFF, 1, "R3");
        drive(0, 0, 0, 8'h00, 0, "R3");
        drive(0, 0, 0, 8'h55, 1, "R3");
        drive(0, 0, 0, 8'hAA, 1, "R3");
        for (int i = 0; i < 8; i++) drive(0, 0, 0, 8'h00, 1'(i % 3 == 0), "R3");
        // R5 signature compaction with varied responses
        drive(0, 1, 0, 8'h81, 0, "R5");
        drive(0, 1, 0, 8'h7E, 1, "R5");
        drive(0, 1, 0, 8'h19, 0, "R5");
        drive(0, 1, 0, 8'hC3, 0, "R5");
        // R4 clear mode ignores d and si
        drive(0, 0, 1, 8'hFF, 1, "R4");
        drive(0, 1, 1, 8'hE7, 0, "R2");
        // R1 reset overrides load
        drive(1, 1, 1, 8'hFF, 1, "R1");
        // R7 lock-up state
        drive(0, 1, 1, 8'hFF, 0, "R2");
        for (int i = 0; i < 3; i++) drive(0, 1, 0, 8'h00, 0, "R7");
        // R6 full period from cleared state
        drive(0, 0, 1, 8'h00, 0, "R4");
        @(negedge clk);
        while (sb_q.size() > 0) @(negedge clk);
        dup = 0;
        hit_ones = 0;
        seen[0] = 1;
        rst = 0; b1 = 1; b2 = 0; d = '0; si = 0;
        for (int i = 1; i < 255; i++) begin
            @(posedge clk);
            #1;
            if (seen[q]) dup = 1;
            if (q == 8'hFF) hit_ones = 1;
            seen[q] = 1;
        end
        check(!dup, "R6 distinct", {7'd0, dup}, 8'h00);
        check(!hit_ones, "R6 no all-ones", {7'd0, hit_ones}, 8'h00);
        @(posedge clk);
        #1;
        check(q == 8'h00, "R6 period", q, 8'h00);
        @(negedge clk);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule